// File: doc/BRIEF.md
# Block Address Translation Matcher

This block maps a 32-bit effective address to a real address through a small set of block translation entries. Two entry arrays are kept: one searched for instruction fetches and one for data accesses. Each entry has an effective-page value, a match mask, a real page base, a supervisor-valid bit, a user-valid bit and a 2-bit protection code. A write port loads one entry at a time into the chosen array.

A lookup presents an effective address, a side select and a privilege flag. Every entry of the selected array is checked in parallel. The lowest-numbered entry that is enabled for the current privilege, matches the address and is writable wins. Entries that match but are read-only or inaccessible are passed over, and the search goes on to the next entry. The result appears one cycle after the request, with a strobe. A miss simply tells the next translation stage that it must handle the access.

Top module: `bat_xlate_top`

## Requirements
- R1: Reset clears both valid bits of every entry on both sides. After reset, and until an entry is written, every lookup returns a miss. `rsp_valid` is low while reset is held.
- R2: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high, and low otherwise. The response fields belong to that request.
- R3: With `req_data` = 0 only the instruction array (loaded with `cfg_side` = 0) is searched. With `req_data` = 1 only the data array (`cfg_side` = 1) is searched.
- R4: With `req_user` = 1 an entry takes part only if its user-valid bit is set. With `req_user` = 0 it takes part only if its supervisor-valid bit is set.
- R5: An entry matches when (`req_ea` AND mask) equals its effective-page value.
- R6: On a hit, `rsp_raddr` = real page base OR (`req_ea` AND NOT mask).
- R7: Protection code 0 (no access) and code 1 (read only) make an entry that matches count as a non-match, so a later entry can still hit. Codes 2 and 3 are read/write.
- R8: When several entries qualify, the one with the lowest index wins.
- R9: A hit returns `rsp_rd`, `rsp_wr` and `rsp_ex` all high. A miss returns them low, with `rsp_raddr` and `rsp_vpage` zero.
- R10: On a hit `rsp_vpage` = {4'hF, `req_ea`[31:12]}. The top nibble is the reserved block-translation tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write one entry |
| cfg_side | input | 1 | Target array: 0 instruction, 1 data |
| cfg_idx | input | 3 | Entry index to write |
| cfg_epage | input | 32 | Effective-page value |
| cfg_mask | input | 32 | Match mask |
| cfg_rpage | input | 32 | Real page base |
| cfg_sv | input | 1 | Supervisor-valid bit |
| cfg_uv | input | 1 | User-valid bit |
| cfg_prot | input | 2 | Protection code |
| req_valid | input | 1 | Lookup request |
| req_ea | input | 32 | Effective address |
| req_data | input | 1 | 0 instruction side, 1 data side |
| req_user | input | 1 | 1 user mode, 0 supervisor mode |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_hit | output | 1 | Translation found |
| rsp_raddr | output | 32 | Real address |
| rsp_vpage | output | 24 | Tagged virtual page number |
| rsp_rd | output | 1 | Read permitted |
| rsp_wr | output | 1 | Write permitted |
| rsp_ex | output | 1 | Execute permitted |

## Verification
The hardest case to reach from the ports is a search that has to pass over entries that match the address. The lookup must go past lower-indexed entries that are read-only or inaccessible and land on a later one. The stimulus loads several data-side entries with the same match window and different protection codes, placing the writable entry above them. It then adds a second writable entry between them to show that the lowest writable index wins. Privilege and side isolation are shown by repeating the same address with the privilege flag and the side select flipped.

// File: rtl/bat_xlate_pkg.sv
// Package: shared entry type and protection codes for the block
// translation matcher.
// Assumes 32-bit effective and real addresses.
package bat_xlate_pkg;

    parameter int XADDR_W = 32;

    // Protection codes: 0 none, 1 read only, 2/3 read-write.
    localparam logic [1:0] PROT_NONE = 2'd0;
    localparam logic [1:0] PROT_RO   = 2'd1;

    typedef enum logic {
        SIDE_INSN = 1'b0,
        SIDE_DATA = 1'b1
    } side_e;

    typedef struct packed {
        logic [XADDR_W-1:0] epage;
        logic [XADDR_W-1:0] mask;
        logic [XADDR_W-1:0] rpage;
        logic               sv;
        logic               uv;
        logic [1:0]         prot;
    } bat_entry_t;

endpackage

// File: rtl/bat_entry_bank.sv
// Module: bat_entry_bank
// Holds one side's array of translation entries and loads one entry
// per write.
// Assumes the write index is in range. Reset clears every entry, so
// both valid bits are zero.
module bat_entry_bank
    import bat_xlate_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  bat_entry_t                   wr_entry,
    output bat_entry_t [NUM_ENTRIES-1:0] slots_o
);

    logic [NUM_ENTRIES-1:0] any_valid;

    // Entry storage: clear on reset, overwrite the addressed slot on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slots_o <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                if (wr_idx == IDX_W'(i)) slots_o[i] <= wr_entry;
            end
        end
    end

    // Per-entry validity summary, used by the reset check below.
    always_comb begin
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            any_valid[i] = slots_o[i].sv | slots_o[i].uv;
        end
    end

    p_reset_invalid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (any_valid == '0))
        else $error("entry valid after reset");

endmodule

// File: rtl/bat_entry_eval.sv
// Module: bat_entry_eval
// Checks one entry against a lookup: privilege enable, masked address
// compare and writability. Also forms the candidate real address.
// Purely combinational.
module bat_entry_eval
    import bat_xlate_pkg::*;
(
    input  bat_entry_t         entry_i,
    input  logic [XADDR_W-1:0] ea_i,
    input  logic               user_i,
    output logic               qualify_o,
    output logic [XADDR_W-1:0] raddr_o
);

    logic lvl_ok;
    logic addr_match;
    logic readable;
    logic writable;

    // Qualification: enabled for this privilege, address in window,
    // read and write allowed.
    always_comb begin
        lvl_ok     = user_i ? entry_i.uv : entry_i.sv;
        addr_match = (ea_i & entry_i.mask) == entry_i.epage;
        readable   = entry_i.prot != PROT_NONE;
        writable   = readable && (entry_i.prot != PROT_RO);
        qualify_o  = lvl_ok && addr_match && readable && writable;
    end

    // Real address: base page plus the offset bits outside the mask.
    always_comb begin
        raddr_o = entry_i.rpage | (ea_i & ~entry_i.mask);
    end

endmodule

// File: rtl/bat_prio_pick.sv
// Module: bat_prio_pick
// Fixed-priority picker: the lowest set request index wins.
// Purely combinational. The grant is one-hot or zero.
module bat_prio_pick #(
    parameter int NUM_REQ = 8,
    localparam int IDX_W = $clog2(NUM_REQ)
) (
    input  logic [NUM_REQ-1:0] req_i,
    output logic [NUM_REQ-1:0] grant_o,
    output logic               any_o,
    output logic [IDX_W-1:0]   idx_o
);

    // Scan from the top down so that the lowest index is kept last.
    always_comb begin
        idx_o = '0;
        for (int i = NUM_REQ - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IDX_W'(i);
        end
        any_o   = |req_i;
        grant_o = any_o ? (NUM_REQ'(1) << idx_o) : '0;
    end

endmodule

// File: rtl/bat_xlate_top.sv
// Module: bat_xlate_top
// Block address translation matcher. Keeps instruction-side and
// data-side entry banks and searches the selected bank in parallel.
// Returns a registered result one cycle after each request.
// Assumes synchronous active-low reset. Writes take effect from the
// cycle after they are presented.
module bat_xlate_top
    import bat_xlate_pkg::*;
#(
    parameter int          NUM_ENTRIES = 8,
    parameter int          PAGE_SHIFT  = 12,
    parameter int          TAG_W       = 4,
    parameter logic [TAG_W-1:0] TAG_VAL = 4'hF,
    localparam int IDX_W = $clog2(NUM_ENTRIES),
    localparam int VP_W  = XADDR_W - PAGE_SHIFT + TAG_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic               cfg_side,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [XADDR_W-1:0] cfg_epage,
    input  logic [XADDR_W-1:0] cfg_mask,
    input  logic [XADDR_W-1:0] cfg_rpage,
    input  logic               cfg_sv,
    input  logic               cfg_uv,
    input  logic [1:0]         cfg_prot,
    input  logic               req_valid,
    input  logic [XADDR_W-1:0] req_ea,
    input  logic               req_data,
    input  logic               req_user,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic [XADDR_W-1:0] rsp_raddr,
    output logic [VP_W-1:0]    rsp_vpage,
    output logic               rsp_rd,
    output logic               rsp_wr,
    output logic               rsp_ex
);

    bat_entry_t                   wr_entry;
    bat_entry_t [NUM_ENTRIES-1:0] bank_q [2];
    bat_entry_t [NUM_ENTRIES-1:0] sel_bank;
    logic [NUM_ENTRIES-1:0]       qual;
    logic [XADDR_W-1:0]           cand_raddr [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0]       grant;
    logic                         any_hit;
    logic [IDX_W-1:0]             hit_idx;

    // Pack the configuration fields into one entry word.
    always_comb begin
        wr_entry = '{epage: cfg_epage, mask: cfg_mask, rpage: cfg_rpage,
                     sv: cfg_sv, uv: cfg_uv, prot: cfg_prot};
    end

    // One bank per side; each bank takes only writes aimed at its side.
    for (genvar s = 0; s < 2; s++) begin : g_side
        bat_entry_bank #(.NUM_ENTRIES(NUM_ENTRIES)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (cfg_we && (cfg_side == 1'(s))),
            .wr_idx   (cfg_idx),
            .wr_entry (wr_entry),
            .slots_o  (bank_q[s])
        );
    end

    // Side select: route the requested bank to the evaluators.
    always_comb begin
        sel_bank = (req_data == SIDE_DATA) ? bank_q[1] : bank_q[0];
    end

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_eval
        bat_entry_eval u_eval (
            .entry_i   (sel_bank[i]),
            .ea_i      (req_ea),
            .user_i    (req_user),
            .qualify_o (qual[i]),
            .raddr_o   (cand_raddr[i])
        );
    end

    bat_prio_pick #(.NUM_REQ(NUM_ENTRIES)) u_pick (
        .req_i   (qual),
        .grant_o (grant),
        .any_o   (any_hit),
        .idx_o   (hit_idx)
    );

    // Response register: strobe follows the request, fields load per request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_raddr <= '0;
            rsp_vpage <= '0;
            rsp_rd    <= 1'b0;
            rsp_wr    <= 1'b0;
            rsp_ex    <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_hit   <= any_hit;
                rsp_raddr <= any_hit ? cand_raddr[hit_idx] : '0;
                rsp_vpage <= any_hit ? {TAG_VAL, req_ea[XADDR_W-1:PAGE_SHIFT]} : '0;
                rsp_rd    <= any_hit;
                rsp_wr    <= any_hit;
                rsp_ex    <= any_hit;
            end
        end
    end

    p_grant_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((grant & ~qual) == '0))
        else $error("picker grant not one-hot within requests");

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid)
        else $error("response strobe missing");

    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid)
        else $error("spurious response strobe");

    p_hit_perm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> (rsp_rd && rsp_wr && rsp_ex))
        else $error("hit without full permissions");

    p_miss_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_raddr == '0 && rsp_vpage == '0
                                     && !rsp_rd && !rsp_wr && !rsp_ex))
        else $error("miss with non-zero result");

    p_vpage_tag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (!rsp_hit ||
                       rsp_vpage == {TAG_VAL, $past(req_ea[XADDR_W-1:PAGE_SHIFT])}))
        else $error("virtual page tag mismatch");

endmodule

// File: tb/bat_xlate_top_bench.sv
module bat_xlate_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_side = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [31:0] cfg_epage = '0;
    logic [31:0] cfg_mask = '0;
    logic [31:0] cfg_rpage = '0;
    logic        cfg_sv = 1'b0;
    logic        cfg_uv = 1'b0;
    logic [1:0]  cfg_prot = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_ea = '0;
    logic        req_data = 1'b0;
    logic        req_user = 1'b0;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [31:0] rsp_raddr;
    logic [23:0] rsp_vpage;
    logic        rsp_rd;
    logic        rsp_wr;
    logic        rsp_ex;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    bat_xlate_top u_bat_xlate_top (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_side(cfg_side), .cfg_idx(cfg_idx),
        .cfg_epage(cfg_epage), .cfg_mask(cfg_mask), .cfg_rpage(cfg_rpage),
        .cfg_sv(cfg_sv), .cfg_uv(cfg_uv), .cfg_prot(cfg_prot),
        .req_valid(req_valid), .req_ea(req_ea), .req_data(req_data),
        .req_user(req_user),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_raddr(rsp_raddr),
        .rsp_vpage(rsp_vpage), .rsp_rd(rsp_rd), .rsp_wr(rsp_wr), .rsp_ex(rsp_ex)
    );

    task automatic check_bit(string req, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic write_entry(logic side, logic [2:0] idx, logic [31:0] ep,
                               logic [31:0] mk, logic [31:0] rp,
                               logic sv, logic uv, logic [1:0] prot);
        @(negedge clk);
        cfg_we = 1'b1; cfg_side = side; cfg_idx = idx;
        cfg_epage = ep; cfg_mask = mk; cfg_rpage = rp;
        cfg_sv = sv; cfg_uv = uv; cfg_prot = prot;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // One lookup; expected results are worked out by the caller.
    task automatic lookup(string req, logic [31:0] ea, logic data, logic user,
                          logic exp_hit, logic [31:0] exp_raddr);
        logic [23:0] exp_vp;
        logic        exp_perm;
        exp_vp   = exp_hit ? {4'hF, ea[31:12]} : 24'h0;
        exp_perm = exp_hit;
        @(negedge clk);
        req_valid = 1'b1; req_ea = ea; req_data = data; req_user = user;
        @(negedge clk);
        req_valid = 1'b0;
        n_checks++;
        if (rsp_valid !== 1'b1 || rsp_hit !== exp_hit || rsp_raddr !== exp_raddr ||
            rsp_vpage !== exp_vp || rsp_rd !== exp_perm || rsp_wr !== exp_perm ||
            rsp_ex !== exp_perm) begin
            n_fail++;
            $display("FAIL %s: ea=%h actual v=%b hit=%b ra=%h vp=%h rwx=%b%b%b expected v=1 hit=%b ra=%h vp=%h rwx=%b%b%b",
                     req, ea, rsp_valid, rsp_hit, rsp_raddr, rsp_vpage,
                     rsp_rd, rsp_wr, rsp_ex, exp_hit, exp_raddr, exp_vp,
                     exp_perm, exp_perm, exp_perm);
        end
    endtask

    task automatic t_reset_state;
        check_bit("R1 rsp_valid in reset", rsp_valid, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        lookup("R1 empty data sup", 32'h1234_5678, 1'b1, 1'b0, 1'b0, 32'h0);
        lookup("R1 empty insn user", 32'h0000_0000, 1'b0, 1'b1, 1'b0, 32'h0);
    endtask

    task automatic t_latency;
        @(negedge clk);
        req_valid = 1'b1; req_ea = 32'h0; req_data = 1'b1; req_user = 1'b0;
        #1 check_bit("R2 no same-cycle strobe", rsp_valid, 1'b0);
        @(negedge clk);
        req_valid = 1'b0;
        check_bit("R2 strobe after one cycle", rsp_valid, 1'b1);
        @(negedge clk);
        check_bit("R2 strobe drops", rsp_valid, 1'b0);
    endtask

    task automatic t_basic_data;
        // data 0: 256 MB window at 0x1000_0000, supervisor only, read-write
        write_entry(1'b1, 3'd0, 32'h1000_0000, 32'hF000_0000, 32'h8000_0000,
                    1'b1, 1'b0, 2'd2);
        lookup("R5 R6 R9 R10 data hit", 32'h1234_5678, 1'b1, 1'b0, 1'b1, 32'h8234_5678);
        lookup("R4 user blocked by sv-only", 32'h1234_5678, 1'b1, 1'b1, 1'b0, 32'h0);
        lookup("R3 insn side ignores data", 32'h1234_5678, 1'b0, 1'b0, 1'b0, 32'h0);
        lookup("R5 outside window", 32'h2000_0000, 1'b1, 1'b0, 1'b0, 32'h0);
    endtask

    task automatic t_basic_insn;
        // insn 3: 128 KB window, user only, protection 3
        write_entry(1'b0, 3'd3, 32'h4000_0000, 32'hFFFE_0000, 32'h0060_0000,
                    1'b0, 1'b1, 2'd3);
        lookup("R6 insn user hit", 32'h4001_ABCD, 1'b0, 1'b1, 1'b1, 32'h0061_ABCD);
        lookup("R4 sup blocked by uv-only", 32'h4001_ABCD, 1'b0, 1'b0, 1'b0, 32'h0);
        lookup("R3 data side ignores insn", 32'h4001_ABCD, 1'b1, 1'b1, 1'b0, 32'h0);
        lookup("R5 just past window", 32'h4002_0000, 1'b0, 1'b1, 1'b0, 32'h0);
    endtask

    task automatic t_skip_and_priority;
        write_entry(1'b1, 3'd1, 32'h5000_0000, 32'hF000_0000, 32'hA000_0000,
                    1'b1, 1'b1, 2'd1);
        write_entry(1'b1, 3'd2, 32'h5000_0000, 32'hF000_0000, 32'hD000_0000,
                    1'b1, 1'b1, 2'd0);
        lookup("R7 only non-writable matches", 32'h5000_0010, 1'b1, 1'b0, 1'b0, 32'h0);
        write_entry(1'b1, 3'd5, 32'h5000_0000, 32'hF000_0000, 32'hC000_0000,
                    1'b1, 1'b1, 2'd2);
        lookup("R7 skip ro/none to entry 5", 32'h5000_0010, 1'b1, 1'b0, 1'b1, 32'hC000_0010);
        write_entry(1'b1, 3'd4, 32'h5000_0000, 32'hF000_0000, 32'hB000_0000,
                    1'b1, 1'b1, 2'd3);
        lookup("R8 lowest writable index 4", 32'h5000_0010, 1'b1, 1'b1, 1'b1, 32'hB000_0010);
    endtask

    task automatic t_reset_again;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check_bit("R1 rsp_valid low in reset", rsp_valid, 1'b0);
        rst_n = 1'b1;
        lookup("R1 entries cleared by reset", 32'h5000_0010, 1'b1, 1'b0, 1'b0, 32'h0);
        lookup("R1 insn cleared by reset", 32'h4001_ABCD, 1'b0, 1'b1, 1'b0, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        t_latency();
        t_basic_data();
        t_basic_insn();
        t_skip_and_priority();
        t_reset_again();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule